// File: doc/BRIEF.md
# Battery-Domain Seconds Counter with Alarm

This block is a small memory-mapped real-time clock that runs from a slow oscillator clock. A reloadable prescaler divides the oscillator down to a one-per-second tick. Each tick advances a free-running 32-bit seconds count and is compared against a 32-bit alarm value. Two sticky event flags, one for the tick and one for the alarm, each have an interrupt enable. The two flag-and-enable pairs drive a single interrupt line.

Software reaches the block over a plain 32-bit register bus with address, write strobe, write data and combinational read data. The slow domain takes time to absorb a write, so every register write is guarded twice. A write-ready status bit must read 1. A key word must also have been written to an unlock register just before the write. Each accepted write then holds write-ready low for a fixed number of oscillator cycles and uses up the unlock. A scratch word holds any value software leaves there, for example a marker that the time has been set.

Top module: `slowclk_rtc`

## Requirements
- R1: After reset, offset 0x00 reads 0x00000080, offset 0x0C reads the reset reload value (default 0x00007FFF), and offsets 0x04, 0x08, 0x34 and 0x3C read 0.
- R2: Offset 0x3C reads its unlock state in bit 31 and zeros elsewhere. A write accepted by the ready gate whose data equals 0x0000A55A sets bit 31. A write of any other value leaves it unchanged.
- R3: While bit 31 of offset 0x3C is 0, writes to offsets 0x00, 0x04, 0x08, 0x0C and 0x34 have no effect, and write-ready stays 1.
- R4: A protected write is accepted only while write-ready (bit 7 of offset 0x00) is 1 and the block is unlocked. After an accepted protected write, write-ready reads 0 for BUSY_CYC (default 3) cycles and the unlock bit reads 0. Any write made while write-ready is 0, including one to 0x3C, is ignored.
- R5: With reload value N-1 at offset 0x0C and the counter enable (bit 0 of 0x00) set, the seconds count at 0x04 rises by one every N clock cycles. The first step comes N cycles after the enabling write.
- R6: While the counter enable is 0, the seconds count and the prescaler phase hold.
- R7: Each tick sets the tick flag (bit 6 of 0x00). Writing 0 to the flag clears it and writing 1 keeps it. A tick in the same cycle as a clearing write leaves the flag set.
- R8: The alarm flag (bit 4 of 0x00) is set on the tick that makes the seconds count equal to the alarm value at 0x08, but only while alarm enable (bit 2) is 1. It clears and keeps under the same write rules as the tick flag.
- R9: The interrupt output is 1 exactly when the tick flag is set with its enable (bit 5) or the alarm flag is set with its enable (bit 3).
- R10: The seconds count wraps from 0xFFFFFFFF to 0. A write to 0x04 in the same cycle as a tick stores the written value.
- R11: Offset 0x34 stores and returns any 32-bit value.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge. A tick can meet a software write to the control register that clears the tick flag. A tick can also meet a software write to the seconds count. The bench counts clock edges from the enabling write. It places the unlock on the edge just before a known tick edge and the protected write on the tick edge itself. It then reads back on the next cycle. The flag must still be set after the clear collides with a tick, and a clear issued one cycle off a tick must take effect. The seconds count must equal the written value, not the incremented one, and must step from that value on the following tick.

// File: rtl/slowclk_rtc_pkg.sv
package slowclk_rtc_pkg;

  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_SECS    = 'h04;
  localparam int OFS_ALARM   = 'h08;
  localparam int OFS_RELOAD  = 'h0C;
  localparam int OFS_SCRATCH = 'h34;
  localparam int OFS_UNLOCK  = 'h3C;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A55A;

  // control register bit positions
  localparam int B_CNT_EN  = 0;
  localparam int B_AL_EN   = 2;
  localparam int B_AL_IE   = 3;
  localparam int B_AL_FLAG = 4;
  localparam int B_HZ_IE   = 5;
  localparam int B_HZ_FLAG = 6;
  localparam int B_READY   = 7;

  // one strobe per protected register, raised for an accepted write
  typedef struct packed {
    logic ctrl;
    logic secs;
    logic alarm;
    logic reload;
    logic scratch;
  } wrStb_t;

endpackage

// File: rtl/slowclk_rtc_ctrl.sv
module slowclk_rtc_ctrl
  import slowclk_rtc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output wrStb_t            stb,
  output logic              writeReady,
  output logic              unlocked
);

  logic hitCtrl, hitSecs, hitAlarm, hitReload, hitScratch, hitUnlock;
  logic isProt, accept, keyWrite;

  assign hitCtrl    = busAddr == ADDR_W'(OFS_CTRL);
  assign hitSecs    = busAddr == ADDR_W'(OFS_SECS);
  assign hitAlarm   = busAddr == ADDR_W'(OFS_ALARM);
  assign hitReload  = busAddr == ADDR_W'(OFS_RELOAD);
  assign hitScratch = busAddr == ADDR_W'(OFS_SCRATCH);
  assign hitUnlock  = busAddr == ADDR_W'(OFS_UNLOCK);

  assign isProt   = hitCtrl | hitSecs | hitAlarm | hitReload | hitScratch;
  assign accept   = busWr && writeReady && unlocked && isProt;
  assign keyWrite = busWr && writeReady && hitUnlock && (busWdata == UNLOCK_KEY);

  always_comb begin
    stb.ctrl    = accept && hitCtrl;
    stb.secs    = accept && hitSecs;
    stb.alarm   = accept && hitAlarm;
    stb.reload  = accept && hitReload;
    stb.scratch = accept && hitScratch;
  end

  // unlock is consumed by the protected write it enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         unlocked <= 1'b0;
    else if (accept)   unlocked <= 1'b0;
    else if (keyWrite) unlocked <= 1'b1;
  end

  generate
    if (BUSY_CYC > 0) begin : g_busy
      localparam int CNT_W = $clog2(BUSY_CYC + 1);
      logic [CNT_W-1:0] busyCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               busyCnt <= '0;
        else if (accept)         busyCnt <= CNT_W'(BUSY_CYC);
        else if (busyCnt != '0)  busyCnt <= busyCnt - CNT_W'(1);
      end
      assign writeReady = (busyCnt == '0);
    end else begin : g_nobusy
      assign writeReady = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/slowclk_rtc_datapath.sv
module slowclk_rtc_datapath
  import slowclk_rtc_pkg::*;
#(
  parameter int          PRESC_W    = 32,
  parameter logic [31:0] RELOAD_RST = 32'd32767
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStb_t             stb,
  input  logic [31:0]        busWdata,
  output logic [PRESC_W-1:0] reloadQ,
  output logic [31:0]        secsQ,
  output logic [31:0]        alarmQ,
  output logic [31:0]        scratchQ,
  output logic               cntEn,
  output logic               alEn,
  output logic               alIe,
  output logic               hzIe,
  output logic               hzFlag,
  output logic               alFlag,
  output logic               tick,
  output logic               irq
);

  logic [PRESC_W-1:0] phase;
  logic [31:0]        secsNext;
  logic               alarmHit;

  assign tick     = cntEn && (phase == reloadQ);
  assign secsNext = secsQ + 32'd1;
  assign alarmHit = tick && alEn && !stb.secs && (secsNext == alarmQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      reloadQ <= PRESC_W'(RELOAD_RST);
    end else if (stb.reload) begin
      phase   <= '0;
      reloadQ <= busWdata[PRESC_W-1:0];
    end else if (cntEn) begin
      phase   <= tick ? '0 : phase + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          secsQ <= '0;
    else if (stb.secs)  secsQ <= busWdata;
    else if (tick)      secsQ <= secsNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ   <= '0;
      scratchQ <= '0;
    end else begin
      if (stb.alarm)   alarmQ   <= busWdata;
      if (stb.scratch) scratchQ <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn <= 1'b0;
      alEn  <= 1'b0;
      alIe  <= 1'b0;
      hzIe  <= 1'b0;
    end else if (stb.ctrl) begin
      cntEn <= busWdata[B_CNT_EN];
      alEn  <= busWdata[B_AL_EN];
      alIe  <= busWdata[B_AL_IE];
      hzIe  <= busWdata[B_HZ_IE];
    end
  end

  // flags: a new event wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hzFlag <= 1'b0;
      alFlag <= 1'b0;
    end else begin
      if (tick)          hzFlag <= 1'b1;
      else if (stb.ctrl) hzFlag <= hzFlag & busWdata[B_HZ_FLAG];
      if (alarmHit)      alFlag <= 1'b1;
      else if (stb.ctrl) alFlag <= alFlag & busWdata[B_AL_FLAG];
    end
  end

  assign irq = (hzFlag & hzIe) | (alFlag & alIe);

endmodule

// File: rtl/slowclk_rtc.sv
module slowclk_rtc
  import slowclk_rtc_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          BUSY_CYC   = 3,
  parameter int          PRESC_W    = 32,
  parameter logic [31:0] RELOAD_RST = 32'd32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  wrStb_t             stb;
  logic               writeReady, unlocked;
  logic [PRESC_W-1:0] reloadQ;
  logic [31:0]        secsQ, alarmQ, scratchQ;
  logic               cntEn, alEn, alIe, hzIe, hzFlag, alFlag, tick;

  slowclk_rtc_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .stb(stb), .writeReady(writeReady),
    .unlocked(unlocked)
  );

  slowclk_rtc_datapath #(.PRESC_W(PRESC_W), .RELOAD_RST(RELOAD_RST)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .reloadQ(reloadQ), .secsQ(secsQ), .alarmQ(alarmQ), .scratchQ(scratchQ),
    .cntEn(cntEn), .alEn(alEn), .alIe(alIe), .hzIe(hzIe),
    .hzFlag(hzFlag), .alFlag(alFlag), .tick(tick), .irq(irq)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_CTRL)) begin
      busRdata[B_READY]   = writeReady;
      busRdata[B_HZ_FLAG] = hzFlag;
      busRdata[B_HZ_IE]   = hzIe;
      busRdata[B_AL_FLAG] = alFlag;
      busRdata[B_AL_IE]   = alIe;
      busRdata[B_AL_EN]   = alEn;
      busRdata[B_CNT_EN]  = cntEn;
    end
    else if (busAddr == ADDR_W'(OFS_SECS))    busRdata = secsQ;
    else if (busAddr == ADDR_W'(OFS_ALARM))   busRdata = alarmQ;
    else if (busAddr == ADDR_W'(OFS_RELOAD))  busRdata = 32'(reloadQ);
    else if (busAddr == ADDR_W'(OFS_SCRATCH)) busRdata = scratchQ;
    else if (busAddr == ADDR_W'(OFS_UNLOCK))  busRdata[31] = unlocked;
  end

endmodule

// File: rtl/slowclk_rtc_chk.sv
module slowclk_rtc_chk
  import slowclk_rtc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input wrStb_t      stb,
  input logic        writeReady,
  input logic        unlocked,
  input logic [31:0] secsQ,
  input logic [31:0] alarmQ,
  input logic [31:0] scratchQ,
  input logic        cntEn,
  input logic        alEn,
  input logic        hzIe,
  input logic        hzFlag,
  input logic        alFlag,
  input logic        tick,
  input logic        irq
);

  // R4
  busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeReady |=> $stable(scratchQ) && $stable(alarmQ));

  // R4
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb) |=> !writeReady && !unlocked);

  // R3
  locked_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(scratchQ) && $stable(alarmQ));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !stb.secs) |=> $stable(secsQ));

  // R7
  tick_flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hzFlag) |-> $past(tick));

  // R8
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alFlag) |-> (secsQ == alarmQ) && $past(alEn));

  // R9
  tick_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hzFlag && hzIe) |-> irq);

endmodule

bind slowclk_rtc slowclk_rtc_chk chk_i (
  .clk(clk), .rstN(rstN), .stb(stb), .writeReady(writeReady),
  .unlocked(unlocked), .secsQ(secsQ), .alarmQ(alarmQ), .scratchQ(scratchQ),
  .cntEn(cntEn), .alEn(alEn), .hzIe(hzIe), .hzFlag(hzFlag),
  .alFlag(alFlag), .tick(tick), .irq(irq)
);

// File: tb/slowclk_rtc_tb_top.sv
module slowclk_rtc_tb_top;

  localparam logic [7:0] A_CTRL = 8'h00, A_SECS = 8'h04, A_ALARM = 8'h08,
                         A_RELOAD = 8'h0C, A_SCR = 8'h34, A_UNL = 8'h3C,
                         A_HOLE = 8'h10;
  localparam logic [31:0] KEY = 32'h0000_A55A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  slowclk_rtc dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  // called between edges; the write lands on the next rising edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr  = a;
    busWdata = d;
    busWr    = 1'b1;
    @(negedge clk);
    busWr    = 1'b0;
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic waitReady();
    logic [31:0] d;
    rd(A_CTRL, d);
    while (!d[7]) begin
      @(negedge clk);
      rd(A_CTRL, d);
    end
  endtask

  task automatic protWrite(input logic [7:0] a, input logic [31:0] d);
    waitReady();
    busWrite(A_UNL, KEY);
    busWrite(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int e;
    logic [31:0] d, s0;
    logic [31:0] badKeys [4];
    logic [31:0] pats [5];
    int ns [5];
    badKeys = '{32'h0000_A55B, 32'h0000_5AA5, 32'h0001_A55A, 32'h0};
    pats    = '{32'hDEAD_BEEF, 32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_0F0F};
    ns      = '{1, 2, 3, 4, 7};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectReg("R1 ctrl", A_CTRL, 32'h80);
    expectReg("R1 secs", A_SECS, 32'h0);
    expectReg("R1 alarm", A_ALARM, 32'h0);
    expectReg("R1 reload", A_RELOAD, 32'h7FFF);
    expectReg("R1 scratch", A_SCR, 32'h0);
    expectReg("R1 unlock", A_UNL, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R3 locked writes have no effect
    busWrite(A_SCR, 32'h1234);
    busWrite(A_ALARM, 32'h55);
    expectReg("R3 scratch locked", A_SCR, 32'h0);
    expectReg("R3 alarm locked", A_ALARM, 32'h0);
    expectReg("R3 ready stays", A_CTRL, 32'h80);

    // R2 wrong keys ignored, right key unlocks
    foreach (badKeys[i]) begin
      busWrite(A_UNL, badKeys[i]);
      expectReg("R2 bad key", A_UNL, 32'h0);
    end
    busWrite(A_UNL, KEY);
    expectReg("R2 key", A_UNL, 32'h8000_0000);

    // R4 busy window and unlock consumption
    busWrite(A_SCR, 32'hCAFE_F00D);
    e = cyc;
    expectReg("R4 scratch written", A_SCR, 32'hCAFE_F00D);
    expectReg("R4 unlock consumed", A_UNL, 32'h0);
    expectReg("R4 busy +0", A_CTRL, 32'h00);
    waitUntil(e + 1);
    expectReg("R4 busy +1", A_CTRL, 32'h00);
    busWrite(A_UNL, KEY);
    expectReg("R4 key ignored while busy", A_UNL, 32'h0);
    expectReg("R4 busy +2", A_CTRL, 32'h00);
    waitUntil(e + 3);
    expectReg("R4 ready back", A_CTRL, 32'h80);

    // R11 scratch sweep
    foreach (pats[i]) begin
      protWrite(A_SCR, pats[i]);
      expectReg("R11 scratch", A_SCR, pats[i]);
    end

    // R5 prescaler sweep
    foreach (ns[i]) begin
      protWrite(A_CTRL, 32'h0);
      protWrite(A_RELOAD, 32'(ns[i] - 1));
      protWrite(A_SECS, 32'h0);
      protWrite(A_CTRL, 32'h1);
      e = cyc;
      waitUntil(e + 3 * ns[i] - 1);
      expectReg("R5 before third tick", A_SECS, 32'd2);
      waitUntil(e + 3 * ns[i]);
      expectReg("R5 third tick", A_SECS, 32'd3);
    end

    // R10 wrap and write-wins collision
    protWrite(A_CTRL, 32'h0);
    protWrite(A_RELOAD, 32'h0);
    protWrite(A_SECS, 32'hFFFF_FFFE);
    protWrite(A_CTRL, 32'h1);
    e = cyc;
    waitUntil(e + 1);
    expectReg("R10 max", A_SECS, 32'hFFFF_FFFF);
    waitUntil(e + 2);
    expectReg("R10 wrap", A_SECS, 32'h0);
    waitUntil(e + 5);
    busWrite(A_UNL, KEY);
    busWrite(A_SECS, 32'd100);
    expectReg("R10 write beats tick", A_SECS, 32'd100);
    waitUntil(e + 8);
    expectReg("R10 step after write", A_SECS, 32'd101);

    // R6 hold while disabled
    protWrite(A_CTRL, 32'h0);
    rd(A_SECS, s0);
    e = cyc;
    waitUntil(e + 12);
    expectReg("R6 secs hold", A_SECS, s0);

    // R8 R9 alarm with enable; tick flag without its enable keeps irq low
    protWrite(A_ALARM, 32'd8);
    protWrite(A_RELOAD, 32'd1);
    protWrite(A_SECS, 32'd5);
    protWrite(A_CTRL, 32'h0D);
    e = cyc;
    waitUntil(e + 5);
    expectReg("R8 no alarm yet", A_CTRL, 32'hCD);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    waitUntil(e + 6);
    expectReg("R8 alarm flag", A_CTRL, 32'hDD);
    check("R9 irq on alarm", {31'b0, irq}, 32'h1);
    protWrite(A_CTRL, 32'h5D);
    expectReg("R8 write one keeps alarm flag", A_CTRL, 32'h5D);
    protWrite(A_CTRL, 32'h0);
    expectReg("R8 write zero clears", A_CTRL, 32'h00);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R8 alarm enable off: no flag
    protWrite(A_SECS, 32'd5);
    protWrite(A_CTRL, 32'h09);
    e = cyc;
    waitUntil(e + 6);
    expectReg("R8 disabled alarm", A_CTRL, 32'hC9);

    // R7 tick flag and clear collision
    protWrite(A_CTRL, 32'h0);
    protWrite(A_RELOAD, 32'd7);
    protWrite(A_SECS, 32'h0);
    protWrite(A_CTRL, 32'h21);
    e = cyc;
    waitUntil(e + 7);
    check("R7 irq before tick", {31'b0, irq}, 32'h0);
    waitUntil(e + 8);
    expectReg("R7 flag on tick", A_CTRL, 32'hE1);
    check("R9 irq on tick", {31'b0, irq}, 32'h1);
    waitUntil(e + 14);
    busWrite(A_UNL, KEY);
    busWrite(A_CTRL, 32'h21);
    expectReg("R7 tick beats clear", A_CTRL, 32'h61);
    waitUntil(e + 19);
    busWrite(A_UNL, KEY);
    busWrite(A_CTRL, 32'h21);
    expectReg("R7 clear off tick", A_CTRL, 32'h21);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    waitUntil(e + 23);
    expectReg("R7 stays clear", A_CTRL, 32'h21);

    // R12 unmapped read
    expectReg("R12 unmapped", A_HOLE, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule